// File: doc/BRIEF.md
# Public-Key Engine Control Front End

This block sits between a 32-bit host register bus and a public-key arithmetic engine. Software programs the operation mode (elliptic-curve or RSA), the exponent and modulus sizes in bits, and a source address and byte count for the operand loader. It then launches a job through a control register. When operand loading is selected, the block first starts the external loader and waits for it to finish. Only after that does it start the arithmetic core. Here the core is a stub with a fixed, parameterised latency that raises a complete event and then a ready event.

Completion is tracked in a status register whose bits are cleared by writing ones. An interrupt line is raised for any status bit whose enable is set. A separate level output shows that a job has fully finished, meaning both the ready and the complete bits are set. The block also contains the engine's operand SRAM. One mode-register bit decides which side owns it: the host bus, through an address window, or the engine, through its own port.

Top module: `pke_ctrl_front`

## Requirements
- R1: After reset every register reads zero, and `irq`, `job_done` and `ldr_start` are low.
- R2: Register readback uses the following layout. At 0x48, the mode is in [5:4] (2 = elliptic-curve, 3 = RSA) and the host-owns-SRAM bit is bit 8. At 0x58, the exponent bit length is in [31:16] and the modulus bit length is in [15:0]. At 0x4c is a 32-bit loader source address. At 0x50 is a byte count in [15:0], whose upper bits read zero. At 0x3f8 are the interrupt enables, bit 2 for ready and bit 1 for complete. Unmapped offsets read zero. Each value also appears on its output port.
- R3: In the control register at 0x00, bit 1 selects operand loading and reads back. Bit 0 launches a job, self-clears and always reads 0.
- R4: A job without loading raises complete (status bit 1 at 0x3fc) roughly CORE_LAT cycles after launch. Ready (bit 2) follows one cycle later.
- R5: `job_done` is high only while both status bits are set.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A new event in the same cycle keeps the bit set.
- R7: `irq` is the OR over status bits of each bit ANDed with its enable.
- R8: A launch issued while a job is running or loading is ignored.
- R9: With loading selected, `ldr_start` pulses once. The core does not run until `ldr_done` arrives, and a job without loading never pulses `ldr_start`.
- R10: SRAM addresses have bit 11 set, with the word index in bits [7:2]. With the host bit clear, host SRAM reads return 0, host SRAM writes are dropped, and the engine port is granted.
- R11: With the host bit set, the engine port is not granted, its reads return 0 and its writes are dropped, while host reads and writes reach the SRAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Host access strobe |
| bus_wr | input | 1 | Host write when high, read when low |
| bus_addr | input | 12 | Byte address; bit 11 selects the SRAM window |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data (same cycle) |
| irq | output | 1 | Interrupt request |
| job_done | output | 1 | Both ready and complete status set |
| ldr_start | output | 1 | One-cycle start pulse to the operand loader |
| ldr_done | input | 1 | Loader finished pulse |
| dma_src | output | 32 | Loader source address |
| dma_len | output | 16 | Loader byte count |
| op_mode | output | 2 | Engine mode code |
| exp_bits | output | 16 | Exponent length in bits |
| mod_bits | output | 16 | Modulus length in bits |
| eng_req | input | 1 | Engine SRAM access request |
| eng_we | input | 1 | Engine SRAM write |
| eng_addr | input | 6 | Engine SRAM word index |
| eng_wdata | input | 32 | Engine SRAM write data |
| eng_rdata | output | 32 | Engine SRAM read data, zero when not granted |
| eng_gnt | output | 1 | Engine SRAM access granted |

## Verification
A table of register writes with readbacks separates correct field placement from masking errors. It writes all ones and checks that only the defined bits survive. A second value then tells the two mode codes apart. Job launches are tried in three patterns: plain, with loading, and repeated while busy. These show whether the loader gates the core, whether a busy launch spawns a second job, and that complete precedes ready. Status clears are tried as single-bit, zero and full writes, which separates write-one-to-clear from plain write behaviour. SRAM ownership is flipped with data planted from one side before the flip, so a dropped write shows up as the old value.

// File: rtl/pke_pkg.sv
package pke_pkg;
  localparam logic [9:0] OFS_CTRL  = 10'h000;
  localparam logic [9:0] OFS_MODE  = 10'h048;
  localparam logic [9:0] OFS_SRC   = 10'h04c;
  localparam logic [9:0] OFS_LEN   = 10'h050;
  localparam logic [9:0] OFS_PARAM = 10'h058;
  localparam logic [9:0] OFS_IEN   = 10'h3f8;
  localparam logic [9:0] OFS_STS   = 10'h3fc;

  localparam logic [1:0] MODE_ECC = 2'd2;
  localparam logic [1:0] MODE_RSA = 2'd3;

  typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_CORE} seq_st_t;
endpackage

// File: rtl/pke_regs.sv
module pke_regs
  import pke_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [9:0]  reg_ofs,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        busy,
  input  logic        ev_cmp,
  input  logic        ev_rdy,
  output logic        start_pls,
  output logic        dma_sel,
  output logic [1:0]  op_mode,
  output logic        host_own,
  output logic [15:0] exp_bits,
  output logic [15:0] mod_bits,
  output logic [31:0] src_addr,
  output logic [15:0] xfer_len,
  output logic        irq,
  output logic        job_done
);
  // index 1 = ready (bus bit 2), index 0 = complete (bus bit 1)
  logic [1:0]  sts_q, sts_d, ien_q;
  logic        start_q, start_d, dma_q, host_q;
  logic [1:0]  mode_q;
  logic [31:0] src_q, param_q;
  logic [15:0] len_q;
  logic        wr_ctrl, wr_mode, wr_src, wr_len, wr_param, wr_ien, wr_sts;

  always_comb begin
    wr_ctrl  = reg_wr && (reg_ofs == OFS_CTRL);
    wr_mode  = reg_wr && (reg_ofs == OFS_MODE);
    wr_src   = reg_wr && (reg_ofs == OFS_SRC);
    wr_len   = reg_wr && (reg_ofs == OFS_LEN);
    wr_param = reg_wr && (reg_ofs == OFS_PARAM);
    wr_ien   = reg_wr && (reg_ofs == OFS_IEN);
    wr_sts   = reg_wr && (reg_ofs == OFS_STS);
    start_d  = wr_ctrl && wdata[0] && !busy;
    sts_d[1] = ev_rdy | (sts_q[1] & ~(wr_sts & wdata[2]));
    sts_d[0] = ev_cmp | (sts_q[0] & ~(wr_sts & wdata[1]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      dma_q   <= 1'b0;
      mode_q  <= 2'd0;
      host_q  <= 1'b0;
      src_q   <= 32'd0;
      len_q   <= 16'd0;
      param_q <= 32'd0;
      ien_q   <= 2'd0;
      sts_q   <= 2'd0;
    end else begin
      start_q <= start_d;
      sts_q   <= sts_d;
      if (wr_ctrl)  dma_q   <= wdata[1];
      if (wr_mode)  begin
        mode_q <= wdata[5:4];
        host_q <= wdata[8];
      end
      if (wr_src)   src_q   <= wdata;
      if (wr_len)   len_q   <= wdata[15:0];
      if (wr_param) param_q <= wdata;
      if (wr_ien)   ien_q   <= wdata[2:1];
    end
  end

  always_comb begin
    unique case (reg_ofs)
      OFS_CTRL:  rdata = {30'd0, dma_q, 1'b0};
      OFS_MODE:  rdata = {23'd0, host_q, 2'd0, mode_q, 4'd0};
      OFS_SRC:   rdata = src_q;
      OFS_LEN:   rdata = {16'd0, len_q};
      OFS_PARAM: rdata = param_q;
      OFS_IEN:   rdata = {29'd0, ien_q, 1'b0};
      OFS_STS:   rdata = {29'd0, sts_q, 1'b0};
      default:   rdata = 32'd0;
    endcase
  end

  assign start_pls = start_q;
  assign dma_sel   = dma_q;
  assign op_mode   = mode_q;
  assign host_own  = host_q;
  assign src_addr  = src_q;
  assign xfer_len  = len_q;
  assign exp_bits  = param_q[31:16];
  assign mod_bits  = param_q[15:0];
  assign irq       = |(sts_q & ien_q);
  assign job_done  = &sts_q;

  AST_CMP_SET_BY_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[0]) |-> $past(ev_cmp)); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_sts && wdata[1] && !ev_cmp) |-> !sts_q[0]); // R6
endmodule

// File: rtl/pke_seq.sv
module pke_seq
  import pke_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_pls,
  input  logic dma_sel,
  input  logic ldr_done,
  input  logic core_done,
  output logic ldr_start,
  output logic core_go,
  output logic busy
);
  seq_st_t st_q, st_d;
  logic    ldr_q, ldr_d, go_q, go_d, dma_q, dma_d;

  always_comb begin
    st_d  = st_q;
    dma_d = dma_q;
    ldr_d = 1'b0;
    go_d  = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (start_pls) begin
        dma_d = dma_sel;
        if (dma_sel) begin
          ldr_d = 1'b1;
          st_d  = SQ_LOAD;
        end else begin
          go_d = 1'b1;
          st_d = SQ_CORE;
        end
      end
      SQ_LOAD: if (ldr_done) begin
        go_d = 1'b1;
        st_d = SQ_CORE;
      end
      SQ_CORE: if (core_done) st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      ldr_q <= 1'b0;
      go_q  <= 1'b0;
      dma_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ldr_q <= ldr_d;
      go_q  <= go_d;
      dma_q <= dma_d;
    end
  end

  assign ldr_start = ldr_q;
  assign core_go   = go_q;
  assign busy      = (st_q != SQ_IDLE);

  AST_CORE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (core_go && dma_q) |-> $past(ldr_done)); // R9
  AST_LOAD_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ldr_start |-> ($past(st_q) == SQ_IDLE)); // R8
endmodule

// File: rtl/pke_core_stub.sv
module pke_core_stub #(
  parameter int LAT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic ev_cmp,
  output logic ev_rdy
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d, cmp_q, cmp_d, rdy_q, rdy_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    cmp_d = 1'b0;
    rdy_d = cmp_q;
    if (go) begin
      cnt_d = CW'(LAT);
      run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q == CW'(1)) begin
        cmp_d = 1'b1;
        run_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      cmp_q <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      cmp_q <= cmp_d;
      rdy_q <= rdy_d;
    end
  end

  assign ev_cmp = cmp_q;
  assign ev_rdy = rdy_q;

  AST_CMP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmp |-> $past(run_q)); // R4
endmodule

// File: rtl/pke_sram.sv
module pke_sram #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          host_own,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [31:0]   h_wdata,
  output logic [31:0]   h_rdata,
  input  logic          e_req,
  input  logic          e_we,
  input  logic [AW-1:0] e_addr,
  input  logic [31:0]   e_wdata,
  output logic [31:0]   e_rdata,
  output logic          e_gnt
);
  logic [31:0] mem [DEPTH];

  assign e_gnt = e_req && !host_own;

  always_ff @(posedge clk) begin
    if (host_own && h_we)    mem[h_addr] <= h_wdata;
    else if (e_gnt && e_we)  mem[e_addr] <= e_wdata;
  end

  assign h_rdata = host_own ? mem[h_addr] : 32'd0;
  assign e_rdata = e_gnt ? mem[e_addr] : 32'd0;
endmodule

// File: rtl/pke_ctrl_front.sv
module pke_ctrl_front #(
  parameter int SRAM_WORDS = 64,
  parameter int CORE_LAT   = 16,
  localparam int SAW = $clog2(SRAM_WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [11:0]    bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           irq,
  output logic           job_done,
  output logic           ldr_start,
  input  logic           ldr_done,
  output logic [31:0]    dma_src,
  output logic [15:0]    dma_len,
  output logic [1:0]     op_mode,
  output logic [15:0]    exp_bits,
  output logic [15:0]    mod_bits,
  input  logic           eng_req,
  input  logic           eng_we,
  input  logic [SAW-1:0] eng_addr,
  input  logic [31:0]    eng_wdata,
  output logic [31:0]    eng_rdata,
  output logic           eng_gnt
);
  logic [1:0]  rst_sync;
  logic        rst_i_n;
  logic        reg_hit, sram_hit, reg_wr, sram_we;
  logic [31:0] reg_rdata, sram_rdata;
  logic        busy, start_pls, dma_sel, host_own;
  logic        core_go, ev_cmp, ev_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  always_comb begin
    reg_hit  = !bus_addr[11] && !bus_addr[10];
    sram_hit = bus_addr[11] && ((bus_addr[10:2] >> SAW) == 9'd0) && (bus_addr[1:0] == 2'd0);
    reg_wr   = bus_sel && bus_wr && reg_hit;
    sram_we  = bus_sel && bus_wr && sram_hit;
    bus_rdata = sram_hit ? sram_rdata : (reg_hit ? reg_rdata : 32'd0);
  end

  pke_regs u_regs (
    .clk(clk), .rst_n(rst_i_n), .reg_wr(reg_wr), .reg_ofs(bus_addr[9:0]),
    .wdata(bus_wdata), .rdata(reg_rdata), .busy(busy), .ev_cmp(ev_cmp),
    .ev_rdy(ev_rdy), .start_pls(start_pls), .dma_sel(dma_sel), .op_mode(op_mode),
    .host_own(host_own), .exp_bits(exp_bits), .mod_bits(mod_bits),
    .src_addr(dma_src), .xfer_len(dma_len), .irq(irq), .job_done(job_done)
  );

  pke_seq u_seq (
    .clk(clk), .rst_n(rst_i_n), .start_pls(start_pls), .dma_sel(dma_sel),
    .ldr_done(ldr_done), .core_done(ev_rdy), .ldr_start(ldr_start),
    .core_go(core_go), .busy(busy)
  );

  pke_core_stub #(.LAT(CORE_LAT)) u_core (
    .clk(clk), .rst_n(rst_i_n), .go(core_go), .ev_cmp(ev_cmp), .ev_rdy(ev_rdy)
  );

  pke_sram #(.DEPTH(SRAM_WORDS)) u_sram (
    .clk(clk), .host_own(host_own), .h_we(sram_we), .h_addr(bus_addr[SAW+1:2]),
    .h_wdata(bus_wdata), .h_rdata(sram_rdata), .e_req(eng_req), .e_we(eng_we),
    .e_addr(eng_addr), .e_wdata(eng_wdata), .e_rdata(eng_rdata), .e_gnt(eng_gnt)
  );

  AST_ENG_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_i_n)
    eng_gnt |-> !host_own); // R11
  AST_NO_GO_WHILE_IDLE_LOAD: assert property (@(posedge clk) disable iff (!rst_i_n)
    ev_cmp |-> busy); // R8
endmodule

// File: tb/pke_ctrl_front_test.sv
`timescale 1ns/1ps
module pke_ctrl_front_test;
  localparam int LAT = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, job_done, ldr_start;
  logic        ldr_done = 1'b0;
  logic [31:0] dma_src;
  logic [15:0] dma_len, exp_bits, mod_bits;
  logic [1:0]  op_mode;
  logic        eng_req = 1'b0, eng_we = 1'b0;
  logic [5:0]  eng_addr = '0;
  logic [31:0] eng_wdata = '0;
  logic [31:0] eng_rdata;
  logic        eng_gnt;

  int nvec = 0, nbad = 0, ldr_cnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pke_ctrl_front #(.SRAM_WORDS(64), .CORE_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .job_done(job_done), .ldr_start(ldr_start), .ldr_done(ldr_done),
    .dma_src(dma_src), .dma_len(dma_len), .op_mode(op_mode), .exp_bits(exp_bits),
    .mod_bits(mod_bits), .eng_req(eng_req), .eng_we(eng_we), .eng_addr(eng_addr),
    .eng_wdata(eng_wdata), .eng_rdata(eng_rdata), .eng_gnt(eng_gnt)
  );

  always @(posedge clk) if (ldr_start) ldr_cnt <= ldr_cnt + 1;

  // {offset, write value, expected readback}
  localparam logic [75:0] VEC [10] = '{
    {12'h048, 32'hFFFF_FFFF, 32'h0000_0130},
    {12'h048, 32'h0000_0020, 32'h0000_0020},
    {12'h058, 32'h0011_0800, 32'h0011_0800},
    {12'h04c, 32'h8000_1234, 32'h8000_1234},
    {12'h050, 32'hABCD_0600, 32'h0000_0600},
    {12'h3f8, 32'hFFFF_FFFF, 32'h0000_0006},
    {12'h3f8, 32'h0000_0000, 32'h0000_0000},
    {12'h000, 32'h0000_0002, 32'h0000_0002},
    {12'h000, 32'h0000_0000, 32'h0000_0000},
    {12'h044, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic poll_sts(output int polls, output logic [31:0] d);
    polls = 0;
    d = '0;
    for (int i = 0; i < 300; i++) begin
      bread(12'h3fc, d);
      if (d != 0) break;
      polls++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int p;
    idle(5);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    foreach (VEC[i]) begin
      bread(VEC[i][75:64], d);
      check("R1 reset readback", d, 32'd0);
    end
    bread(12'h3fc, d); check("R1 status reset", d, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 job_done", {31'd0, job_done}, 32'd0);
    check("R1 ldr_start", {31'd0, ldr_start}, 32'd0);

    // R2 / R3 table walk
    for (int i = 0; i < 10; i++) begin
      bwrite(VEC[i][75:64], VEC[i][63:32]);
      bread(VEC[i][75:64], d);
      check(VEC[i][75:64] == 12'h000 ? "R3 ctrl readback" : "R2 register readback", d, VEC[i][31:0]);
    end
    check("R2 op_mode", {30'd0, op_mode}, 32'd2);
    check("R2 exp_bits", {16'd0, exp_bits}, 32'h11);
    check("R2 mod_bits", {16'd0, mod_bits}, 32'h800);
    check("R2 dma_src", dma_src, 32'h8000_1234);
    check("R2 dma_len", {16'd0, dma_len}, 32'h600);

    // R4 R5 R7 plain job
    bwrite(12'h3f8, 32'h2);
    ldr_cnt = 0;
    bwrite(12'h000, 32'h1);
    poll_sts(p, d);
    check("R4 latency window", {31'd0, (p >= LAT) && (p <= LAT + 4)}, 32'd1);
    check("R4 complete first", d, 32'h2);
    check("R5 job_done low with one bit", {31'd0, job_done}, 32'd0);
    check("R7 irq on enabled complete", {31'd0, irq}, 32'd1);
    bread(12'h3fc, d);
    check("R4 ready follows", d, 32'h6);
    check("R5 job_done both bits", {31'd0, job_done}, 32'd1);
    bread(12'h000, d);
    check("R3 start reads zero", d, 32'd0);
    check("R9 no loader pulse without DMA", ldr_cnt, 0);

    // R6 R7 write-one-to-clear
    bwrite(12'h3fc, 32'h4);
    bread(12'h3fc, d);
    check("R6 clear ready only", d, 32'h2);
    check("R5 job_done drops", {31'd0, job_done}, 32'd0);
    bwrite(12'h3fc, 32'h0);
    bread(12'h3fc, d);
    check("R6 zero write keeps", d, 32'h2);
    bwrite(12'h3f8, 32'h4);
    check("R7 irq masked", {31'd0, irq}, 32'd0);
    bwrite(12'h3fc, 32'h2);
    bread(12'h3fc, d);
    check("R6 clear complete", d, 32'h0);

    // R8 launch while busy
    bwrite(12'h000, 32'h1);
    bwrite(12'h000, 32'h1);
    poll_sts(p, d);
    idle(2);
    bwrite(12'h3fc, 32'h6);
    idle(3 * LAT);
    bread(12'h3fc, d);
    check("R8 no second job", d, 32'h0);

    // R9 loader sequencing
    ldr_cnt = 0;
    bwrite(12'h000, 32'h3);
    idle(3 * LAT);
    bread(12'h3fc, d);
    check("R9 core waits for loader", d, 32'h0);
    bwrite(12'h000, 32'h3);
    idle(2);
    check("R8 R9 single loader pulse", ldr_cnt, 1);
    @(negedge clk); ldr_done = 1'b1;
    @(negedge clk); ldr_done = 1'b0;
    poll_sts(p, d);
    check("R9 job finishes after loader", d, 32'h2);
    check("R9 loader count", ldr_cnt, 1);
    bwrite(12'h3fc, 32'h6);
    bwrite(12'h000, 32'h0);

    // R10 engine owns SRAM
    bwrite(12'h048, 32'h0);
    @(negedge clk);
    eng_req = 1'b1; eng_we = 1'b1; eng_addr = 6'd5; eng_wdata = 32'h1111_1111;
    #2 check("R10 engine granted", {31'd0, eng_gnt}, 32'd1);
    @(negedge clk);
    eng_addr = 6'd3; eng_wdata = 32'h5A5A_5A5A;
    @(negedge clk);
    eng_we = 1'b0;
    #2 check("R10 engine reads back", eng_rdata, 32'h5A5A_5A5A);
    eng_req = 1'b0;
    bwrite(12'h814, 32'h2222_2222);
    bread(12'h814, d);
    check("R10 host read blocked", d, 32'h0);

    // R11 host owns SRAM
    bwrite(12'h048, 32'h100);
    bread(12'h814, d);
    check("R10 host write was dropped", d, 32'h1111_1111);
    bread(12'h80c, d);
    check("R11 host sees engine data", d, 32'h5A5A_5A5A);
    bwrite(12'h80c, 32'h1234_5678);
    @(negedge clk);
    eng_req = 1'b1; eng_we = 1'b1; eng_addr = 6'd3; eng_wdata = 32'h9999_9999;
    #2 check("R11 engine not granted", {31'd0, eng_gnt}, 32'd0);
    check("R11 engine read zero", eng_rdata, 32'd0);
    @(negedge clk);
    eng_req = 1'b0; eng_we = 1'b0;
    bread(12'h80c, d);
    check("R11 engine write dropped", d, 32'h1234_5678);

    finished = 1;
    summary();
    $finish;
  end
endmodule